// File: doc/BRIEF.md
# Master Clock Ratio Detector and Speed Selector

This block sits at the clock front end of an audio converter. It runs on the master clock. It measures how many master-clock cycles fit into one period of the frame (left/right) clock, then maps that count onto one of eight supported oversampling ratios. The measured ratio is accepted only when it is stable from frame to frame.

The sampling-speed mode (half, normal or double) comes from a 2-bit speed-select input. When that input selects automatic mode, the mode is instead derived from the accepted ratio. The block also gates a de-emphasis request, so de-emphasis runs only at normal speed.

The frame clock may arrive with any phase and any duty cycle relative to the master clock. Only its rising edges are used, after a two-stage synchronizer. The filter datapath lies outside this block.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is held and right after it is released, `locked_o` is 0 and `ratio_code_o` is 0.
- R2: A period is the number of `clk_i` cycles between two successive rising edges of `frame_i`. The first rising edge after reset only starts a measurement. The first completed period can never produce lock on its own.
- R3: A period maps to a ratio code when it lies within ±2 counts of that ratio. The codes are: 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 = 512, 5 = 768, 6 = 1024, 7 = 1536.
- R4: At the end of each period, lock is set only if all three conditions hold:
  - the period is within ±2 counts of the period before it;
  - the period maps to a code;
  - that code is allowed in the current mode.
  In every other case lock is cleared.
- R5: A period that maps to no code, or to a code not allowed in the current mode, clears `locked_o` and leaves `ratio_code_o` unchanged.
- R6: Speed-select values 00, 01 and 10 give normal, double and half speed. In each of these, `speed_o` equals the speed-select value. The allowed codes are 2–5 at normal speed, 0–3 at double speed and 4–7 at half speed.
- R7: Speed-select 11 is automatic mode. All codes are allowed. `speed_o` is half (10) for codes 6–7, normal (00) for codes 4–5 and double (01) for codes 0–3, taken from the held `ratio_code_o`.
- R8: `deemph_en_o` is 1 exactly when `deemph_i` is 1 and `speed_o` is normal (00).
- R9: `ratio_code_o` changes only at the end of a period that sets lock.
- R10: The duty cycle and phase of `frame_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame clock, asynchronous to clk_i |
| speed_sel_i | input | 2 | Speed select: 00 normal, 01 double, 10 half, 11 auto |
| deemph_i | input | 1 | De-emphasis request |
| speed_o | output | 2 | Resolved speed: 00 normal, 01 double, 10 half |
| ratio_code_o | output | 3 | Held ratio code |
| locked_o | output | 1 | Ratio accepted on the last period |
| deemph_en_o | output | 1 | De-emphasis enable |

## Verification
The assertions assume that `speed_sel_i` and `deemph_i` are quasi-static. They are expected to change only well away from a frame edge, so each period is judged under one mode setting. The stimulus applies each new setting ten cycles after a rising frame edge, long after the synchronized edge has been committed. Frame periods stay far above the synchronizer depth, which keeps every period measurable. A bench model replays the same stream of periods to predict lock and the held code.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

  localparam int NUM_RATIOS   = 8;
  localparam int RATIO_CODE_W = 3;

  localparam logic [1:0] SPD_NORMAL = 2'b00;
  localparam logic [1:0] SPD_DOUBLE = 2'b01;
  localparam logic [1:0] SPD_HALF   = 2'b10;
  localparam logic [1:0] SPD_AUTO   = 2'b11;

  // 128 or 192 base, doubled per step of code[2:1]
  function automatic int ratio_nominal(input logic [RATIO_CODE_W-1:0] code);
    int base;
    base = code[0] ? 192 : 128;
    return base << code[2:1];
  endfunction

  function automatic logic ratio_allowed(input logic [RATIO_CODE_W-1:0] code,
                                         input logic [1:0] sel);
    logic ok;
    case (sel)
      SPD_NORMAL: ok = (code >= 3'd2) && (code <= 3'd5);
      SPD_DOUBLE: ok = (code <= 3'd3);
      SPD_HALF:   ok = (code >= 3'd4);
      default:    ok = 1'b1;
    endcase
    return ok;
  endfunction

  function automatic logic [1:0] speed_from_code(input logic [RATIO_CODE_W-1:0] code);
    logic [1:0] spd;
    if (code >= 3'd6)      spd = SPD_HALF;
    else if (code >= 3'd4) spd = SPD_NORMAL;
    else                   spd = SPD_DOUBLE;
    return spd;
  endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic rise_o
);

  logic [SYNC_STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SYNC_STAGES-1:0], frame_i};
  end

  assign rise_o = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];

endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      period_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        cnt_q    <= '0;
        primed_q <= 1'b1;
        valid_o  <= primed_q;
        // saturated count never matches a ratio
        period_o <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ratio_lock.sv
module ratio_lock
  import mclk_ratio_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [1:0]              speed_sel_i,
  output logic [RATIO_CODE_W-1:0] code_o,
  output logic                    locked_o
);

  logic [NUM_RATIOS-1:0]   hit;
  logic [RATIO_CODE_W-1:0] hit_code;
  logic [CNT_W-1:0]        prev_q;
  logic                    prev_valid_q;
  logic [CNT_W-1:0]        diff;
  logic                    agree;
  logic                    accept;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_match
    localparam int NOM = ratio_nominal(RATIO_CODE_W'(g));
    assign hit[g] = (int'(period_i) >= NOM - TOL) && (int'(period_i) <= NOM + TOL);
  end

  always_comb begin
    hit_code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) hit_code = RATIO_CODE_W'(i);
    end
  end

  assign diff   = (period_i >= prev_q) ? period_i - prev_q : prev_q - period_i;
  assign agree  = prev_valid_q && (int'(diff) <= TOL);
  assign accept = agree && (|hit) && ratio_allowed(hit_code, speed_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= '0;
      prev_valid_q <= 1'b0;
      code_o       <= '0;
      locked_o     <= 1'b0;
    end else if (valid_i) begin
      prev_q       <= period_i;
      prev_valid_q <= 1'b1;
      locked_o     <= accept;
      if (accept) code_o <= hit_code;
    end
  end

endmodule

// File: rtl/speed_resolver.sv
module speed_resolver
  import mclk_ratio_pkg::*;
(
  input  logic [1:0]              speed_sel_i,
  input  logic [RATIO_CODE_W-1:0] code_i,
  input  logic                    deemph_i,
  output logic [1:0]              speed_o,
  output logic                    deemph_en_o
);

  always_comb begin
    speed_o     = (speed_sel_i == SPD_AUTO) ? speed_from_code(code_i) : speed_sel_i;
    deemph_en_o = deemph_i && (speed_o == SPD_NORMAL);
  end

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mclk_ratio_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic [1:0] speed_sel_i,
  input  logic       deemph_i,
  output logic [1:0] speed_o,
  output logic [2:0] ratio_code_o,
  output logic       locked_o,
  output logic       deemph_en_o
);

  logic             frame_rise;
  logic [CNT_W-1:0] meas_period;
  logic             meas_valid;

  frame_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .rise_o (frame_rise)
  );

  period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (frame_rise),
    .period_o(meas_period),
    .valid_o (meas_valid)
  );

  ratio_lock #(.CNT_W(CNT_W), .TOL(TOL)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (meas_valid),
    .period_i   (meas_period),
    .speed_sel_i(speed_sel_i),
    .code_o     (ratio_code_o),
    .locked_o   (locked_o)
  );

  speed_resolver u_speed (
    .speed_sel_i(speed_sel_i),
    .code_i     (ratio_code_o),
    .deemph_i   (deemph_i),
    .speed_o    (speed_o),
    .deemph_en_o(deemph_en_o)
  );

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] speed_sel_i,
  input logic       deemph_i,
  input logic [1:0] speed_o,
  input logic [2:0] ratio_code_o,
  input logic       locked_o,
  input logic       deemph_en_o,
  input logic       commit_i
);

  // R9
  code_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_code_o) |-> ($past(commit_i) && locked_o));

  // R4
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(commit_i));

  // R8
  deemph_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deemph_en_o |-> (deemph_i && speed_o == 2'b00));

  // R6
  fixed_speed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_sel_i != 2'b11) |-> (speed_o == speed_sel_i));

  // R7
  auto_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_sel_i == 2'b11 && ratio_code_o[2:1] == 2'b11) |-> (speed_o == 2'b10));

  // R7
  auto_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_sel_i == 2'b11 && !ratio_code_o[2]) |-> (speed_o == 2'b01));

endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .speed_sel_i (speed_sel_i),
  .deemph_i    (deemph_i),
  .speed_o     (speed_o),
  .ratio_code_o(ratio_code_o),
  .locked_o    (locked_o),
  .deemph_en_o (deemph_en_o),
  .commit_i    (meas_valid)
);

// File: tb/mclk_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module mclk_ratio_detect_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       dem = 1'b1;
  logic [1:0] speed;
  logic [2:0] code;
  logic       locked;
  logic       dem_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  int  m_last = -1;
  int  m_prev = -1;
  int  m_code = 0;
  bit  m_lock = 1'b0;

  always #2.5 clk = ~clk;

  mclk_ratio_detect dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_i     (frame),
    .speed_sel_i (sel),
    .deemph_i    (dem),
    .speed_o     (speed),
    .ratio_code_o(code),
    .locked_o    (locked),
    .deemph_en_o (dem_en)
  );

  function automatic int nom_of(int c);
    int t[8] = '{128, 192, 256, 384, 512, 768, 1024, 1536};
    return t[c];
  endfunction

  function automatic int classify(int m);
    for (int i = 0; i < 8; i++) begin
      if (m >= nom_of(i) - 2 && m <= nom_of(i) + 2) return i;
    end
    return -1;
  endfunction

  function automatic bit allowed(int c, logic [1:0] s);
    case (s)
      2'b00: return c == 2 || c == 3 || c == 4 || c == 5;
      2'b01: return c == 0 || c == 1 || c == 2 || c == 3;
      2'b10: return c == 4 || c == 5 || c == 6 || c == 7;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int exp_speed(logic [1:0] s, int c);
    if (s != 2'b11) return int'(s);
    if (c >= 6) return 2;
    if (c >= 4) return 0;
    return 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R2 R4 R5: reference update at each rising frame edge
  task automatic model_edge();
    int c;
    int d;
    if (m_last >= 0) begin
      c = classify(m_last);
      d = (m_prev >= 0) ? ((m_last > m_prev) ? m_last - m_prev : m_prev - m_last) : 99;
      if (m_prev >= 0 && d <= 2 && c >= 0 && allowed(c, sel)) begin
        m_lock = 1'b1;
        m_code = c;
      end else begin
        m_lock = 1'b0;
      end
      m_prev = m_last;
    end
  endtask

  task automatic drive_period(int n, int hi, bit apply, logic [1:0] s, bit d);
    model_edge();
    for (int c = 0; c < n; c++) begin
      frame = (c < hi);
      if (apply && c == 10) begin
        sel = s;
        dem = d;
      end
      @(posedge clk);
      #1;
    end
    m_last = n;
  endtask

  task automatic check_outputs(string tag);
    check(locked == m_lock, {tag, " R4 lock"}, int'(locked), int'(m_lock));
    check(int'(code) == m_code, {tag, " R3 R5 R9 code"}, int'(code), m_code);
    check(int'(speed) == exp_speed(sel, m_code), {tag, " R6 R7 speed"},
          int'(speed), exp_speed(sel, m_code));
    check(dem_en == (dem && exp_speed(sel, m_code) == 0), {tag, " R8 deemph"},
          int'(dem_en), int'(dem && exp_speed(sel, m_code) == 0));
  endtask

  // R10: random duty cycle on every period
  task automatic run_cfg(string tag, logic [1:0] s, bit d, int nom, int periods, bit jit);
    for (int p = 0; p < periods; p++) begin
      int n;
      n = nom + (jit ? int'($urandom_range(2)) - 1 : 0);
      drive_period(n, int'($urandom_range(n - 1, 1)), p == 0, s, d);
    end
    check_outputs(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    #1;
    // R1
    check(locked == 1'b0, "R1 reset lock", int'(locked), 0);
    check(code == 3'd0, "R1 reset code", int'(code), 0);
    check(speed == 2'b00, "R1 R6 reset speed", int'(speed), 0);
    check(dem_en == 1'b1, "R1 R8 reset deemph", int'(dem_en), 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(locked == 1'b0 && code == 3'd0, "R1 after release", int'(code), 0);

    // R2: one period alone cannot lock
    drive_period(256, 100, 1'b0, 2'b00, 1'b1);
    drive_period(256, 100, 1'b0, 2'b00, 1'b1);
    check(locked == 1'b0, "R2 first period", int'(locked), 0);
    check(locked == m_lock, "R2 model", int'(locked), int'(m_lock));

    run_cfg("normal 256",  2'b00, 1'b1, 256, 4, 1'b0);
    run_cfg("normal 1536 R5", 2'b00, 1'b1, 1536, 3, 1'b0);
    run_cfg("half 1536",   2'b10, 1'b1, 1536, 3, 1'b0);
    run_cfg("double 128",  2'b01, 1'b1, 128, 4, 1'b1);
    run_cfg("double 512 R5", 2'b01, 1'b0, 512, 3, 1'b0);
    run_cfg("auto 1024 R7", 2'b11, 1'b1, 1024, 3, 1'b1);
    run_cfg("auto 768 R7",  2'b11, 1'b1, 768, 3, 1'b1);
    run_cfg("auto 384 R7",  2'b11, 1'b1, 384, 4, 1'b1);
    run_cfg("auto 300 R5",  2'b11, 1'b1, 300, 3, 1'b0);
    run_cfg("auto 192 R3",  2'b11, 1'b0, 192, 4, 1'b0);
    run_cfg("edge tol R3",  2'b00, 1'b1, 258, 4, 1'b0);
    run_cfg("over tol R5",  2'b00, 1'b1, 259, 4, 1'b0);

    // R4: alternating periods never agree
    drive_period(256, 30, 1'b1, 2'b00, 1'b0);
    drive_period(266, 200, 1'b0, 2'b00, 1'b0);
    drive_period(256, 128, 1'b0, 2'b00, 1'b0);
    drive_period(266, 5, 1'b0, 2'b00, 1'b0);
    check_outputs("alternate R4");
    check(locked == 1'b0, "R4 alternate unlocked", int'(locked), 0);

    for (int k = 0; k < 24; k++) begin
      int pick;
      int nom;
      pick = int'($urandom_range(9));
      nom = (pick < 8) ? nom_of(pick) : ((pick == 8) ? 640 : 100 + int'($urandom_range(60)));
      run_cfg("random", 2'($urandom_range(3)), 1'($urandom_range(1)), nom,
              3 + int'($urandom_range(1)), 1'($urandom_range(1)));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule